// File: doc/BRIEF.md
# Four-Bit Shift and Rotate Selector

This combinational unit takes a 4-bit operand and returns one transformed copy of it. A 2-bit mode picks the operation family: logical shifting, arithmetic shifting or rotation. A 2-bit select picks the action within that family. In the two shift families the select either passes the operand through, moves it right by one place or moves it left by one place. In the rotation family the select gives a rotation amount of zero to three places, always in the same direction.

Every output bit comes from its own four-way selector. Each selector's four inputs are wired from the operand according to the bit's position. A separate detector raises a flag when an arithmetic left move changes the sign of the value. The unit has no clock and no storage, so the result follows the inputs within the same cycle.

Top module: `sru_top`

## Requirements
- R1: Mode code 00 selects logical shifting, 01 selects arithmetic shifting and 10 selects rotation.
- R2: In either shift family, select codes 00 and 01 return the operand unchanged.
- R3: In logical mode, select 10 moves the operand right by one place, puts 0 in bit 3 and drops bit 0 (1101 gives 0110).
- R4: In arithmetic mode, select 10 moves the operand right by one place and keeps the old bit 3 in bit 3, which gives the floor of half the signed value (1100 gives 1110).
- R5: In either shift family, select 11 moves the operand left by one place, puts 0 in bit 0 and drops bit 3 (1011 gives 0110).
- R6: In rotation mode, output bit i equals operand bit (i + k) mod 4, where k is the select value read as an unsigned number. Select 01 on A3..A0 gives A0 A3 A2 A1, and select 00 returns the operand.
- R7: The overflow flag is 1 only in arithmetic mode with select 11 when operand bit 3 differs from bit 2. It is 0 for every other combination of mode, select and operand.
- R8: Mode code 11 gives the same result and flag as mode code 00 for every operand and select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 4 | Operand A3..A0 |
| sel_i | input | 2 | Action select within the chosen family |
| mode_i | input | 2 | Operation family: 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| res_o | output | 4 | Transformed operand D3..D0 |
| ovf_o | output | 1 | Sign change on an arithmetic left move |

## Verification
The embedded checks are immediate and are evaluated whenever the inputs move. They assume that every input bit holds a known 0 or 1, and they are skipped while any input is unknown. They also assume that the outputs have settled once the inputs have settled. The bench changes all three inputs together just after a rising clock edge and samples half a period later, so every input is always driven and each combination stays steady long enough to be observed. The bench sweeps every operand under each mode and select code, so the passthrough, fill, rotation and flag rules are each exercised on all sixteen values.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_ROT   = 2'b10,
    MODE_LOGIC2 = 2'b11
  } sru_mode_e;

  localparam logic [1:0] SEL_RIGHT = 2'b10;
  localparam logic [1:0] SEL_LEFT  = 2'b11;
endpackage

// File: rtl/sru_mux4.sv
module sru_mux4 (
  input  logic [3:0] d_i,
  input  logic [1:0] s_i,
  output logic       y_o
);
  always_comb begin
    case (s_i)
      2'd0:    y_o = d_i[0];
      2'd1:    y_o = d_i[1];
      2'd2:    y_o = d_i[2];
      default: y_o = d_i[3];
    endcase
  end
endmodule

// File: rtl/sru_lane.sv
// Builds the four candidate inputs for output bit IDX.
module sru_lane #(
  parameter int W   = 4,
  parameter int IDX = 0
) (
  input  logic [W-1:0] opnd_i,
  input  logic         msb_fill_i,
  input  logic         rot_i,
  output logic [3:0]   cand_o
);
  localparam int RIGHT_SRC = (IDX + 1) % W;
  localparam int LEFT_SRC  = (IDX + W - 1) % W;

  logic       rfill;
  logic       lfill;
  logic [3:0] rot_c;

  assign rfill = (IDX == W-1) ? msb_fill_i : opnd_i[RIGHT_SRC];
  assign lfill = (IDX == 0)   ? 1'b0       : opnd_i[LEFT_SRC];

  for (genvar k = 0; k < 4; k++) begin : g_rot
    localparam int ROT_SRC = (IDX + k) % W;
    assign rot_c[k] = opnd_i[ROT_SRC];
  end

  always_comb begin
    if (rot_i) cand_o = rot_c;
    else       cand_o = {lfill, rfill, opnd_i[IDX], opnd_i[IDX]};
  end
endmodule

// File: rtl/sru_ovf.sv
module sru_ovf (
  input  logic       msb_i,
  input  logic       nxt_i,
  input  logic       ari_i,
  input  logic [1:0] sel_i,
  output logic       ovf_o
);
  logic left_sel;
  assign left_sel = (sel_i == sru_pkg::SEL_LEFT);
  assign ovf_o    = ari_i & left_sel & (msb_i ^ nxt_i);
endmodule

// File: rtl/sru_top.sv
module sru_top #(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd_i,
  input  logic [1:0]   sel_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  import sru_pkg::*;

  localparam int MSB = W - 1;

  sru_mode_e mode;
  logic      rot;
  logic      ari;
  logic      msb_fill;

  assign mode     = sru_mode_e'(mode_i);
  assign rot      = (mode == MODE_ROT);
  assign ari      = (mode == MODE_ARITH);
  assign msb_fill = ari & opnd_i[MSB];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [3:0] cand;
    sru_lane #(.W(W), .IDX(i)) lane_i (
      .opnd_i    (opnd_i),
      .msb_fill_i(msb_fill),
      .rot_i     (rot),
      .cand_o    (cand)
    );
    sru_mux4 mux_i (
      .d_i(cand),
      .s_i(sel_i),
      .y_o(res_o[i])
    );
  end

  sru_ovf ovf_i (
    .msb_i(opnd_i[MSB]),
    .nxt_i(opnd_i[MSB-1]),
    .ari_i(ari),
    .sel_i(sel_i),
    .ovf_o(ovf_o)
  );

  always_comb begin
    if (!$isunknown({opnd_i, sel_i, mode_i})) begin
      if (ovf_o)
        AST_FLAG_SIGN: assert (res_o[MSB] != opnd_i[MSB]) else $error("flag without sign change"); // R7
      if (mode_i != MODE_ARITH)
        AST_FLAG_MODE: assert (!ovf_o) else $error("flag outside arithmetic mode"); // R7
      if (!rot && !sel_i[1])
        AST_PASS_THRU: assert (res_o == opnd_i) else $error("passthrough altered operand"); // R2
      if (rot)
        AST_ROT_ONES: assert ($countones(res_o) == $countones(opnd_i)) else $error("rotation lost bits"); // R6
      if (ari && sel_i == SEL_RIGHT)
        AST_ASR_SIGN: assert (res_o[MSB] == opnd_i[MSB]) else $error("sign not kept"); // R4
      if (!rot && sel_i == SEL_LEFT)
        AST_LSB_ZERO: assert (!res_o[0]) else $error("left move bit 0 not zero"); // R5
    end
  end
endmodule

// File: tb/sru_top_tb_top.sv
module sru_top_tb_top;
  logic       clk = 1'b0;
  logic [3:0] opnd;
  logic [1:0] sel;
  logic [1:0] mode;
  logic [3:0] res;
  logic       ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sru_top dut_i (
    .opnd_i(opnd), .sel_i(sel), .mode_i(mode),
    .res_o(res), .ovf_o(ovf)
  );

  task automatic apply(input logic [1:0] m, input logic [1:0] s, input logic [3:0] a);
    @(posedge clk);
    mode = m; sel = s; opnd = a;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp_r, input logic exp_f);
    checks++;
    if (res !== exp_r || ovf !== exp_f) begin
      errors++;
      $display("FAIL %s mode=%b sel=%b a=%b actual res=%b ovf=%b expected res=%b ovf=%b",
               req, mode, sel, opnd, res, ovf, exp_r, exp_f);
    end
  endtask

  task automatic t_initial();
    apply(2'b00, 2'b00, 4'b0000);
    check("R2", 4'b0000, 1'b0);
  endtask

  task automatic t_pass();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 16; a++) begin
          apply(2'(m), 2'(s), 4'(a));
          check("R2", 4'(a), 1'b0);
        end
  endtask

  task automatic t_lsr();
    apply(2'b00, 2'b10, 4'b1101);
    check("R3", 4'b0110, 1'b0);
    for (int a = 0; a < 16; a++) begin
      apply(2'b00, 2'b10, 4'(a));
      check("R3", 4'(a / 2), 1'b0);
    end
  endtask

  task automatic t_asr();
    apply(2'b01, 2'b10, 4'b1100);
    check("R4", 4'b1110, 1'b0);
    for (int a = -8; a < 8; a++) begin
      int q;
      q = (a >= 0) ? a / 2 : -((-a + 1) / 2);
      apply(2'b01, 2'b10, 4'(a));
      check("R4", 4'(q), 1'b0);
    end
  endtask

  task automatic t_left();
    apply(2'b00, 2'b11, 4'b1011);
    check("R5", 4'b0110, 1'b0);
    for (int a = 0; a < 16; a++) begin
      apply(2'b00, 2'b11, 4'(a));
      check("R5", 4'((a * 2) % 16), 1'b0);
    end
  endtask

  task automatic t_rot();
    apply(2'b10, 2'b01, 4'b1000);
    check("R6", 4'b0100, 1'b0);
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 16; a++) begin
        logic [7:0] dbl;
        dbl = {4'(a), 4'(a)} >> s;
        apply(2'b10, 2'(s), 4'(a));
        check("R6", dbl[3:0], 1'b0);
      end
  endtask

  task automatic t_flag();
    for (int a = -8; a < 8; a++) begin
      int p;
      logic f;
      p = a * 2;
      f = (p < -8) || (p > 7);
      apply(2'b01, 2'b11, 4'(a));
      check("R7", 4'(p), f);
    end
  endtask

  task automatic t_mode3();
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 16; a++) begin
        logic [3:0] e;
        case (s)
          0, 1: e = 4'(a);
          2:    e = 4'(a / 2);
          default: e = 4'((a * 2) % 16);
        endcase
        apply(2'b11, 2'(s), 4'(a));
        check("R8", e, 1'b0);
      end
    apply(2'b11, 2'b11, 4'b0100);
    check("R1", 4'b1000, 1'b0);
  endtask

  initial begin
    t_initial();
    t_pass();
    t_lsr();
    t_asr();
    t_left();
    t_rot();
    t_flag();
    t_mode3();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule